// File: doc/BRIEF.md
# Consumer Digital Audio Serial Transmitter

This block sends 48 kHz stereo PCM as a consumer-format serial digital audio stream on one biphase-mark coded line. At the start of every frame it takes one left/right sample pair, either from the host link or from the local ADC path. It places the pair into two 32-slot subframes. Each subframe carries a sync preamble, zero auxiliary bits, the audio field, validity, user, channel-status and parity bits. The channel-status stream carries a control code and a category code taken from control inputs. All other channel-status bits are sent as zero.

All timing comes from a clock enable. The enable divides the master clock down to one line half-cell per `CLK_DIV` clocks. With a 24.576 MHz master clock and the default divider of 4, this gives 6.144 MHz, which is 128 times the 48 kHz frame rate. A one-clock `pair_take` pulse shows the frame boundary at which the inputs were sampled. This lets the producer change samples safely right after the pulse.

Top module: `spdif_tx_top`

## Requirements
- R1: While `en` is 0 (and under reset) `spdif_out` and `pair_take` are held low. After `en` returns to 1, transmission restarts at frame 0 of a block with a preamble taken from a low line.
- R2: A line half-cell lasts exactly `CLK_DIV` clocks. A frame is 128 half-cells, so consecutive `pair_take` pulses are 128*`CLK_DIV` clocks apart.
- R3: The left subframe of block frame 0 starts with preamble B. Other left subframes start with M, and every right subframe starts with W. Starting from a low line, these are the 8 half-cell patterns B=11101000, M=11100010 and W=11100100, first half-cell leftmost. Starting from a high line, they are inverted.
- R4: Slots 4 to 31 are biphase-mark coded. The line toggles at the start of every cell, and it toggles again mid-cell when the bit is 1.
- R5: Slots 4 to 11 carry zero. Slots 12 to 27 carry the 16-bit sample, least significant bit first (slot 27 is the sample MSB). Slot 28 (validity) and slot 29 (user) are zero.
- R6: Slot 31 makes the count of ones over slots 4 to 31 even. As a result, the line is low before every preamble.
- R7: With `src_sel`=0 the host-link pair is sent, and with `src_sel`=1 the ADC pair is sent.
- R8: With `mute`=1 at frame capture, the audio slots of both subframes are zero. Framing, channel status and parity continue normally.
- R9: Slot 30 of both subframes in block frame n carries channel-status bit n. Bit 0 is 0. Bits 1 to 5 are `ctl_code[0]` to `ctl_code[4]`, and bits 8 to 15 are `cat_code[0]` to `cat_code[7]`. All other bits are 0.
- R10: `cat_code` and `ctl_code` are sampled only at the start of block frame 0. A change made mid-block first appears in the next block.
- R11: `pair_take` is high for exactly one clock, in the cycle where the first half-cell of a frame appears on `spdif_out`. The sample pair, `src_sel` and `mute` are captured at that same clock edge and hold for the whole frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Transmitter enable; 0 powers down and forces the line low |
| mute | input | 1 | Zero the audio slots of the captured pair |
| src_sel | input | 1 | 0 selects host-link samples, 1 selects ADC samples |
| cat_code | input | 8 | Category code for channel-status bits 8 to 15 |
| ctl_code | input | 5 | Control code for channel-status bits 1 to 5 |
| host_l | input | SAMPLE_W | Host-link left sample |
| host_r | input | SAMPLE_W | Host-link right sample |
| adc_l | input | SAMPLE_W | ADC left sample |
| adc_r | input | SAMPLE_W | ADC right sample |
| spdif_out | output | 1 | Biphase-mark coded serial line |
| pair_take | output | 1 | One-clock pulse marking frame start and sample capture |

## Verification
At block frame 0, the same clock edge captures the sample pair with its mute and source choice, and also loads the channel-status codes. The bench changes samples, mute, source and both codes at one instant just before that edge, and also changes the codes in the middle of a block. It then decodes each received frame from the line. It checks that the audio field follows the pair captured at that frame, and that slot 30 follows the codes captured at the start of the block, not the newer ones. The expected waveform is rebuilt from these captured values for every half-cell.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;
   typedef enum logic [1:0] {PRE_B = 2'd0, PRE_M = 2'd1, PRE_W = 2'd2} pre_kind_t;

   localparam int SLOTS_PER_SUB  = 32;
   localparam int HALVES_PER_FRM = 4 * SLOTS_PER_SUB;
   localparam int AUDIO_TOP_SLOT = 28;
   localparam int AUDIO_MAX_W    = 20;
   localparam int CS_SLOT        = 30;
   localparam int PARITY_SLOT    = 31;

   // Half-cell pattern for a line that was low before the preamble (MSB first).
   function automatic logic [7:0] pre_pattern(input pre_kind_t kind);
      logic [7:0] p;
      case (kind)
         PRE_B:   p = 8'b1110_1000;
         PRE_M:   p = 8'b1110_0010;
         default: p = 8'b1110_0100;
      endcase
      return p;
   endfunction
endpackage

// File: rtl/spdif_ce_gen.sv
module spdif_ce_gen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic ce
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt_q;

   generate
      if ((DIV & (DIV - 1)) == 0) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate

   assign ce = (cnt_q == LAST);

   AST_CE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      ce |=> !ce); // R2
endmodule

// File: rtl/spdif_frame_seq.sv
module spdif_frame_seq #(
   parameter int FRAMES = 192,
   localparam int FW    = $clog2(FRAMES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          ce,
   output logic          step,
   output logic [6:0]    hc,
   output logic [FW-1:0] frm
);
   localparam logic [FW-1:0] FRM_LAST = FW'(FRAMES - 1);

   assign step = ce & en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hc  <= '0;
         frm <= '0;
      end else if (!en) begin
         hc  <= '0;
         frm <= '0;
      end else if (ce) begin
         hc <= hc + 1'b1;
         if (hc == 7'd127) frm <= (frm == FRM_LAST) ? '0 : frm + 1'b1;
      end
   end

   AST_FRM_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (frm <= FRM_LAST)); // R3
endmodule

// File: rtl/spdif_payload.sv
module spdif_payload #(
   parameter int SAMPLE_W = 16,
   parameter int FRAMES   = 192,
   localparam int FW      = $clog2(FRAMES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take,
   input  logic                blk_take,
   input  logic                src_sel,
   input  logic                mute,
   input  logic [7:0]          cat_code,
   input  logic [4:0]          ctl_code,
   input  logic [SAMPLE_W-1:0] host_l,
   input  logic [SAMPLE_W-1:0] host_r,
   input  logic [SAMPLE_W-1:0] adc_l,
   input  logic [SAMPLE_W-1:0] adc_r,
   input  logic [5:0]          slot_sel,
   input  logic [FW-1:0]       frm,
   output logic                slot_bit
);
   import spdif_tx_pkg::*;

   logic [SAMPLE_W-1:0] smp_l_q, smp_r_q;
   logic [SAMPLE_W-1:0] pick_l, pick_r;
   logic [15:0]         cs_q;
   logic                cs_now;
   logic [31:0]         word_l, word_r, word_sel;

   generate
      if (SAMPLE_W == AUDIO_MAX_W) begin : g_full
         assign pick_l = src_sel ? adc_l : host_l;
         assign pick_r = src_sel ? adc_r : host_r;
      end else begin : g_narrow
         // Narrow samples sit in the top of the audio field; low slots stay zero.
         assign pick_l = src_sel ? adc_l : host_l;
         assign pick_r = src_sel ? adc_r : host_r;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_l_q <= '0;
         smp_r_q <= '0;
      end else if (take) begin
         smp_l_q <= mute ? '0 : pick_l;
         smp_r_q <= mute ? '0 : pick_r;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cs_q <= '0;
      else if (blk_take) cs_q <= {cat_code, 2'b00, ctl_code, 1'b0};
   end

   assign cs_now = (32'(frm) < 32'd16) ? cs_q[frm[3:0]] : 1'b0;

   function automatic logic [31:0] build_word(input logic [SAMPLE_W-1:0] s,
                                              input logic cs);
      logic [31:0] w;
      w = '0;
      for (int i = 0; i < SAMPLE_W; i++) w[AUDIO_TOP_SLOT - SAMPLE_W + i] = s[i];
      w[CS_SLOT]     = cs;
      w[PARITY_SLOT] = ^w[CS_SLOT:4];
      return w;
   endfunction

   assign word_l   = build_word(smp_l_q, cs_now);
   assign word_r   = build_word(smp_r_q, cs_now);
   assign word_sel = slot_sel[5] ? word_r : word_l;
   assign slot_bit = word_sel[slot_sel[4:0]];

   AST_MUTE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (take && mute) |=> (smp_l_q == '0 && smp_r_q == '0)); // R8
   AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_take |=> $stable(cs_q)); // R10
endmodule

// File: rtl/spdif_bmc_enc.sv
module spdif_bmc_enc (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       step,
   input  logic [6:0] hc,
   input  logic       blk_first,
   input  logic       data_bit,
   output logic       line_q,
   output logic       pair_take_q
);
   import spdif_tx_pkg::*;

   pre_kind_t  kind;
   logic [7:0] pat;
   logic       is_pre;
   logic [2:0] pidx;
   logic       pol_q;
   logic       nxt;

   assign kind   = hc[6] ? PRE_W : (blk_first ? PRE_B : PRE_M);
   assign pat    = pre_pattern(kind);
   assign is_pre = (hc[5:3] == 3'd0);
   assign pidx   = hc[2:0];

   always_comb begin
      if (is_pre) begin
         if (pidx == 3'd0) nxt = pat[7] ^ line_q;
         else              nxt = pat[3'd7 - pidx] ^ pol_q;
      end else if (!hc[0]) begin
         nxt = ~line_q;
      end else begin
         nxt = data_bit ? ~line_q : line_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q      <= 1'b0;
         pol_q       <= 1'b0;
         pair_take_q <= 1'b0;
      end else if (!en) begin
         line_q      <= 1'b0;
         pol_q       <= 1'b0;
         pair_take_q <= 1'b0;
      end else begin
         pair_take_q <= step && (hc == 7'd0);
         if (step) begin
            line_q <= nxt;
            if (is_pre && pidx == 3'd0) pol_q <= line_q;
         end
      end
   end

   AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !line_q && !pair_take_q); // R1
   AST_CELL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !is_pre && !hc[0]) |=> (line_q != $past(line_q))); // R4
   AST_PRE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (step && hc[5:0] == 6'd0) |-> !line_q); // R6
   AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pair_take_q |=> !pair_take_q); // R11
endmodule

// File: rtl/spdif_tx_top.sv
module spdif_tx_top #(
   parameter int CLK_DIV          = 4,
   parameter int FRAMES_PER_BLOCK = 192,
   parameter int SAMPLE_W         = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                mute,
   input  logic                src_sel,
   input  logic [7:0]          cat_code,
   input  logic [4:0]          ctl_code,
   input  logic [SAMPLE_W-1:0] host_l,
   input  logic [SAMPLE_W-1:0] host_r,
   input  logic [SAMPLE_W-1:0] adc_l,
   input  logic [SAMPLE_W-1:0] adc_r,
   output logic                spdif_out,
   output logic                pair_take
);
   localparam int FW = $clog2(FRAMES_PER_BLOCK);

   generate
      if (CLK_DIV < 2) begin : g_bad_div
         $error("CLK_DIV must be at least 2");
      end
      if (FRAMES_PER_BLOCK < 16) begin : g_bad_blk
         $error("FRAMES_PER_BLOCK must cover the 16 coded status bits");
      end
      if (SAMPLE_W < 1 || SAMPLE_W > 20) begin : g_bad_w
         $error("SAMPLE_W must lie in 1..20");
      end
   endgenerate

   logic          ce, step;
   logic [6:0]    hc;
   logic [FW-1:0] frm;
   logic          take, blk_take, data_bit;

   spdif_ce_gen #(.DIV(CLK_DIV)) u_ce (
      .clk(clk), .rst_n(rst_n), .ce(ce));

   spdif_frame_seq #(.FRAMES(FRAMES_PER_BLOCK)) u_seq (
      .clk(clk), .rst_n(rst_n), .en(en), .ce(ce),
      .step(step), .hc(hc), .frm(frm));

   assign take     = step && (hc == 7'd0);
   assign blk_take = take && (frm == '0);

   spdif_payload #(.SAMPLE_W(SAMPLE_W), .FRAMES(FRAMES_PER_BLOCK)) u_pay (
      .clk(clk), .rst_n(rst_n), .take(take), .blk_take(blk_take),
      .src_sel(src_sel), .mute(mute), .cat_code(cat_code), .ctl_code(ctl_code),
      .host_l(host_l), .host_r(host_r), .adc_l(adc_l), .adc_r(adc_r),
      .slot_sel(hc[6:1]), .frm(frm), .slot_bit(data_bit));

   spdif_bmc_enc u_enc (
      .clk(clk), .rst_n(rst_n), .en(en), .step(step), .hc(hc),
      .blk_first(frm == '0), .data_bit(data_bit),
      .line_q(spdif_out), .pair_take_q(pair_take));
endmodule

// File: tb/sim_spdif_tx_top.sv
module sim_spdif_tx_top;
   localparam int DIV = 2;
   localparam int FRAMES = 24;
   localparam int SW = 16;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, en, mute, src_sel;
   logic [7:0] cat_code;
   logic [4:0] ctl_code;
   logic [SW-1:0] host_l, host_r, adc_l, adc_r;
   logic spdif_out, pair_take;

   spdif_tx_top #(.CLK_DIV(DIV), .FRAMES_PER_BLOCK(FRAMES), .SAMPLE_W(SW)) u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .mute(mute), .src_sel(src_sel),
      .cat_code(cat_code), .ctl_code(ctl_code),
      .host_l(host_l), .host_r(host_r), .adc_l(adc_l), .adc_r(adc_r),
      .spdif_out(spdif_out), .pair_take(pair_take));

   int n_chk = 0;
   int n_fail = 0;
   int fidx;
   logic last_lvl;
   logic [15:0] cap_l, cap_r;
   logic cap_mute;
   logic [7:0] blk_cat;
   logic [4:0] blk_ctl;
   logic [127:0] hcv;

   task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic cs_bit(input int n, input logic [7:0] cat, input logic [4:0] ctl);
      if (n >= 1 && n <= 5) return ctl[n-1];
      if (n >= 8 && n <= 15) return cat[n-8];
      return 1'b0;
   endfunction

   function automatic logic [31:0] exp_word(input logic [15:0] s, input logic cs);
      logic [31:0] w;
      w = '0;
      w[27:12] = s;
      w[30] = cs;
      w[31] = ^w[30:4];
      return w;
   endfunction

   function automatic logic [63:0] exp_sub(input logic [31:0] w, input logic [7:0] pat, input logic prev);
      logic [63:0] r;
      logic lvl;
      for (int k = 0; k < 8; k++) r[k] = pat[7-k] ^ prev;
      lvl = r[7];
      for (int s = 4; s < 32; s++) begin
         lvl = ~lvl;
         r[2*s] = lvl;
         if (w[s]) lvl = ~lvl;
         r[2*s+1] = lvl;
      end
      return r;
   endfunction

   function automatic logic [31:0] decode(input logic [63:0] h);
      logic [31:0] d;
      d = '0;
      for (int s = 4; s < 32; s++) d[s] = h[2*s] ^ h[2*s+1];
      return d;
   endfunction

   task automatic wait_take();
      int n;
      n = 0;
      while (pair_take !== 1'b1 && n < 20000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 20000) chk(1'b0, "R11 no frame start seen", 64'(pair_take), 64'd1);
   endtask

   task automatic capture();
      cap_mute = mute;
      cap_l = mute ? 16'h0 : (src_sel ? adc_l : host_l);
      cap_r = mute ? 16'h0 : (src_sel ? adc_r : host_r);
      if (fidx == 0) begin
         blk_cat = cat_code;
         blk_ctl = ctl_code;
      end
   endtask

   task automatic rand_inputs(input bit allow_mute);
      host_l = 16'($urandom);
      host_r = 16'($urandom);
      adc_l = 16'($urandom);
      adc_r = 16'($urandom);
      src_sel = 1'($urandom % 2);
      mute = allow_mute ? 1'(($urandom % 3) == 0) : 1'b0;
   endtask

   task automatic collect_check();
      logic [31:0] wl, wr, dl, dr;
      logic [63:0] el, er, al, ar;
      logic cs;
      hcv[0] = spdif_out;
      @(negedge clk);
      chk(pair_take == 1'b0, "R11 pulse width", 64'(pair_take), 64'd0);
      repeat (DIV - 1) @(negedge clk);
      hcv[1] = spdif_out;
      for (int k = 2; k < 128; k++) begin
         repeat (DIV) @(negedge clk);
         hcv[k] = spdif_out;
      end
      repeat (DIV) @(negedge clk);
      chk(pair_take == 1'b1, "R2 frame period", 64'(pair_take), 64'd1);
      cs = cs_bit(fidx, blk_cat, blk_ctl);
      wl = exp_word(cap_l, cs);
      wr = exp_word(cap_r, cs);
      el = exp_sub(wl, (fidx == 0) ? 8'b1110_1000 : 8'b1110_0010, last_lvl);
      er = exp_sub(wr, 8'b1110_0100, el[63]);
      al = hcv[63:0];
      ar = hcv[127:64];
      chk(al[7:0] == el[7:0] && ar[7:0] == er[7:0], "R3 preambles",
          64'({al[7:0], ar[7:0]}), 64'({el[7:0], er[7:0]}));
      chk(al == el, "R4 left waveform", al, el);
      chk(ar == er, "R4 right waveform", ar, er);
      dl = decode(al);
      dr = decode(ar);
      chk(dl[11:4] == 0 && dl[29:28] == 0 && dr[11:4] == 0 && dr[29:28] == 0,
          "R5 fixed slots", 64'({dl, dr}), 64'({wl, wr}));
      chk(dl[27:12] == cap_l && dr[27:12] == cap_r, cap_mute ? "R8 muted audio" : "R7 source audio",
          64'({dl[27:12], dr[27:12]}), 64'({cap_l, cap_r}));
      chk(dl[30] == cs && dr[30] == cs, "R9 R10 status bit",
          64'({dl[30], dr[30]}), 64'({cs, cs}));
      chk(^dl[31:4] == 1'b0 && ^dr[31:4] == 1'b0, "R6 parity",
          64'({dl[31], dr[31]}), 64'({wl[31], wr[31]}));
      last_lvl = hcv[127];
      fidx = (fidx + 1) % FRAMES;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog expired actual=hung expected=done");
      summary();
   end

   initial begin
      int bad;
      void'($urandom(32'h5eed_0743));
      rst_n = 1'b0; en = 1'b0; mute = 1'b0; src_sel = 1'b0;
      cat_code = 8'b1001_1010; ctl_code = 5'b00010;
      host_l = '0; host_r = '0; adc_l = '0; adc_r = '0;
      repeat (5) @(negedge clk);
      chk(spdif_out == 1'b0 && pair_take == 1'b0, "R1 reset state",
          64'({spdif_out, pair_take}), 64'd0);
      rst_n = 1'b1;
      rand_inputs(1'b0);
      en = 1'b1;
      fidx = 0;
      last_lvl = 1'b0;
      wait_take();
      // Plain traffic; codes change mid-block (R10) at frame 9.
      for (int i = 0; i < 30; i++) begin
         capture();
         rand_inputs(1'b0);
         if (i == 9) begin
            cat_code = 8'($urandom);
            ctl_code = 5'($urandom);
         end
         if (i == 12) begin
            host_l = 16'hFFFF; host_r = 16'h0000; src_sel = 1'b0;
         end
         if (i == 13) begin
            adc_l = 16'h8001; adc_r = 16'h7FFE; src_sel = 1'b1;
         end
         collect_check();
      end
      // Mute mixed in; codes and samples change together before block start.
      for (int i = 0; i < 20; i++) begin
         capture();
         rand_inputs(1'b1);
         if (fidx == FRAMES - 1 || i == 5) begin
            cat_code = 8'($urandom);
            ctl_code = 5'($urandom);
            mute = 1'b1;
         end
         collect_check();
      end
      // Power down (R1).
      en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      bad = 0;
      for (int i = 0; i < 300; i++) begin
         if (spdif_out !== 1'b0 || pair_take !== 1'b0) bad++;
         if (i % 40 == 0) rand_inputs(1'b1);
         @(negedge clk);
      end
      chk(bad == 0, "R1 disabled line low", 64'(bad), 64'd0);
      fidx = 0;
      last_lvl = 1'b0;
      cat_code = 8'($urandom);
      ctl_code = 5'($urandom);
      mute = 1'b0;
      en = 1'b1;
      wait_take();
      for (int i = 0; i < 26; i++) begin
         capture();
         rand_inputs(1'b1);
         collect_check();
      end
      summary();
   end
endmodule